// File: doc/BRIEF.md
# Scalar Float Widening Converter

This unit takes one IEEE-754 binary32 operand and widens it exactly to binary64, then assembles a 256-bit destination value around that result. The converted value always targets the low 64-bit lane. The remaining bits of the result depend on a two-bit merge policy:

- **Legacy** keeps the old destination contents above bit 63.
- **Three-operand** copies bits 127:64 from a first source operand and clears everything above bit 127.
- **Masked** behaves like three-operand, and also gates the low lane with a one-bit writemask. A masked-off lane either keeps the old low lane (merge) or is cleared (zero).

Two status flags report conversion conditions: invalid, for a signaling NaN, and denormal, for a subnormal input.

The block sits in an execution pipeline behind the decoder. The decoder supplies the low 32 bits of the convert-from source and bits 127:64 of the first source; the other source bits play no part in the operation. A request is presented with a one-cycle valid strobe. The registered result, valid and flags appear on the next cycle.

Top module: `fp_widen_unit`

## Requirements
- R1: A normal binary32 input `conv_src` is written to `result[63:0]` as binary64. The sign is copied, the 8-bit exponent is increased by 896 to give the 11-bit exponent, and the 23-bit fraction sits in fraction bits 51:29 with zeros below. No flag is raised.
- R2: A subnormal input (exponent 0, fraction nonzero) is normalized into a normal binary64 value of equal magnitude, and `flag_denorm` is raised.
- R3: A zero input (exponent 0, fraction 0) becomes a binary64 zero, and an infinity input (exponent 255, fraction 0) becomes a binary64 infinity. Both keep their sign and raise no flag.
- R4: A NaN input (exponent 255, fraction nonzero) gives a binary64 NaN with the same sign. The 23-bit payload sits in fraction bits 51:29, and bit 51 is forced to 1. `flag_invalid` is raised only when input fraction bit 22 was 0 (signaling).
- R5: With `mode` = 0 (legacy), `result[255:64]` equals `dest_old[255:64]`, and the low lane always receives the converted value.
- R6: With `mode` = 1 (three-operand) or `mode` = 2 (masked), `result[127:64]` equals `upper_src` and `result[255:128]` is zero.
- R7: With `mode` = 2, the converted value is written to `result[63:0]` when `mask_bit` is 1 or `mask_en` is 0. With `mode` = 1 it is always written.
- R8: With `mode` = 2, `mask_en` = 1 and `mask_bit` = 0, `result[63:0]` equals `dest_old[63:0]` when `zero_sel` = 0 and zero when `zero_sel` = 1. In both cases neither flag is raised, whatever the input.
- R9: `out_valid` is high exactly one cycle after `in_valid`, and `result` and the flags reflect that request in that cycle. The flags are low whenever `out_valid` is low, and `result` holds its value through cycles without a request.
- R10: While `rst` is high and on the first cycle after it, `out_valid`, both flags and `result` are zero.
- R11: `mode` = 3 is treated exactly as legacy mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 2 | Merge policy: 0 legacy, 1 three-operand, 2 masked, 3 as legacy |
| mask_en | input | 1 | Writemask in use (masked mode only) |
| mask_bit | input | 1 | Writemask bit for the low lane |
| zero_sel | input | 1 | 1 = zero a masked-off lane, 0 = merge old value |
| conv_src | input | 32 | binary32 operand (low doubleword of convert-from source) |
| upper_src | input | 64 | Bits 127:64 of the first source operand |
| dest_old | input | 256 | Previous destination register value |
| out_valid | output | 1 | Result strobe |
| result | output | 256 | New destination register value |
| flag_invalid | output | 1 | Signaling NaN converted |
| flag_denorm | output | 1 | Subnormal input converted |

## Verification
The temporal properties compare each output cycle against the inputs sampled on the previous edge. They therefore assume that every request lasts a single cycle and that its operands are valid only while `in_valid` is high. The bench keeps to this by driving every operand on the falling edge together with the strobe, and by dropping the strobe for at least one idle cycle before the next request. All four `mode` codes are defined, so no input restriction applies there. The sweep covers every exponent code with boundary fraction patterns under both signs, and every mode, mask and zeroing combination with randomized upper-lane and old-destination data.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int SP_W      = 1 + SP_EXP_W + SP_FRAC_W;
  localparam int DP_EXP_W  = 11;
  localparam int DP_FRAC_W = 52;
  localparam int DP_W      = 1 + DP_EXP_W + DP_FRAC_W;
  localparam int SP_BIAS   = 127;
  localparam int DP_BIAS   = 1023;

  typedef enum logic [1:0] {
    MODE_LEGACY = 2'd0,
    MODE_3OP    = 2'd1,
    MODE_MASKED = 2'd2,
    MODE_RSVD   = 2'd3
  } merge_mode_e;

  typedef struct packed {
    logic invalid;
    logic denorm;
  } fp_flags_t;
endpackage

// File: rtl/fpw_lzc.sv
module fpw_lzc #(
  parameter int W = 23,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt,
  output logic          all_zero
);
  // Scan from the LSB so the highest set bit wins last.
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = CW'(W - 1 - i);
    end
  end

  assign all_zero = ~|vec;
endmodule

// File: rtl/fpw_widen.sv
module fpw_widen
  import fpw_pkg::*;
(
  input  logic [SP_W-1:0] sp,
  output logic [DP_W-1:0] dp,
  output fp_flags_t       flags
);
  localparam int EXP_ADJ = DP_BIAS - SP_BIAS;
  localparam int LZ_W    = $clog2(SP_FRAC_W + 1);
  localparam int PAD_W   = DP_FRAC_W - SP_FRAC_W;

  logic                 sgn;
  logic [SP_EXP_W-1:0]  exp_in;
  logic [SP_FRAC_W-1:0] frac_in;
  logic                 exp_max, exp_zero, frac_zero;
  logic [LZ_W-1:0]      lz;
  logic [SP_FRAC_W-1:0] norm_frac;
  logic [SP_FRAC_W-1:0] sub_frac;
  logic [DP_EXP_W-1:0]  sub_exp;
  logic [DP_EXP_W-1:0]  nrm_exp;

  assign sgn      = sp[SP_W-1];
  assign exp_in   = sp[SP_W-2 -: SP_EXP_W];
  assign frac_in  = sp[SP_FRAC_W-1:0];
  assign exp_max  = &exp_in;
  assign exp_zero = ~|exp_in;

  fpw_lzc #(.W(SP_FRAC_W)) u_lzc (
    .vec      (frac_in),
    .cnt      (lz),
    .all_zero (frac_zero)
  );

  // Subnormal: bring the leading one to the hidden position and drop it.
  assign norm_frac = frac_in << lz;
  assign sub_frac  = {norm_frac[SP_FRAC_W-2:0], 1'b0};
  assign sub_exp   = DP_EXP_W'(EXP_ADJ) - DP_EXP_W'(lz);
  assign nrm_exp   = DP_EXP_W'(exp_in) + DP_EXP_W'(EXP_ADJ);

  always_comb begin
    flags = '0;
    if (exp_max) begin
      if (frac_zero) begin
        dp = {sgn, {DP_EXP_W{1'b1}}, {DP_FRAC_W{1'b0}}};
      end else begin
        dp = {sgn, {DP_EXP_W{1'b1}}, 1'b1, frac_in[SP_FRAC_W-2:0], {PAD_W{1'b0}}};
        flags.invalid = ~frac_in[SP_FRAC_W-1];
      end
    end else if (exp_zero) begin
      if (frac_zero) begin
        dp = {sgn, {(DP_W-1){1'b0}}};
      end else begin
        dp = {sgn, sub_exp, sub_frac, {PAD_W{1'b0}}};
        flags.denorm = 1'b1;
      end
    end else begin
      dp = {sgn, nrm_exp, frac_in, {PAD_W{1'b0}}};
    end
  end
endmodule

// File: rtl/fpw_lane_merge.sv
module fpw_lane_merge
  import fpw_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int MAX_W = 256,
  localparam int HI_W = VEC_W - DP_W
) (
  input  logic [1:0]       mode,
  input  logic             mask_en,
  input  logic             mask_bit,
  input  logic             zero_sel,
  input  logic [DP_W-1:0]  conv,
  input  fp_flags_t        conv_flags,
  input  logic [HI_W-1:0]  upper_src,
  input  logic [MAX_W-1:0] dest_old,
  output logic [MAX_W-1:0] merged,
  output fp_flags_t        merged_flags
);
  merge_mode_e m;
  logic        three_op;
  logic        lane_en;

  assign m        = merge_mode_e'(mode);
  assign three_op = (m == MODE_3OP) || (m == MODE_MASKED);
  assign lane_en  = (m != MODE_MASKED) || !mask_en || mask_bit;

  always_comb begin
    merged = dest_old;
    if (three_op) begin
      merged[MAX_W-1:VEC_W] = '0;
      merged[VEC_W-1:DP_W]  = upper_src;
    end
    if (lane_en)       merged[DP_W-1:0] = conv;
    else if (zero_sel) merged[DP_W-1:0] = '0;
    merged_flags = lane_en ? conv_flags : '0;
  end
endmodule

// File: rtl/fp_widen_unit.sv
module fp_widen_unit
  import fpw_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int MAX_W = 256,
  localparam int HI_W = VEC_W - DP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       mode,
  input  logic             mask_en,
  input  logic             mask_bit,
  input  logic             zero_sel,
  input  logic [SP_W-1:0]  conv_src,
  input  logic [HI_W-1:0]  upper_src,
  input  logic [MAX_W-1:0] dest_old,
  output logic             out_valid,
  output logic [MAX_W-1:0] result,
  output logic             flag_invalid,
  output logic             flag_denorm
);
  logic [DP_W-1:0]  conv;
  fp_flags_t        conv_flags;
  logic [MAX_W-1:0] merged;
  fp_flags_t        merged_flags;
  fp_flags_t        flags_q;

  fpw_widen u_widen (
    .sp    (conv_src),
    .dp    (conv),
    .flags (conv_flags)
  );

  fpw_lane_merge #(.VEC_W(VEC_W), .MAX_W(MAX_W)) u_merge (
    .mode         (mode),
    .mask_en      (mask_en),
    .mask_bit     (mask_bit),
    .zero_sel     (zero_sel),
    .conv         (conv),
    .conv_flags   (conv_flags),
    .upper_src    (upper_src),
    .dest_old     (dest_old),
    .merged       (merged),
    .merged_flags (merged_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags_q   <= '0;
    end else begin
      out_valid <= in_valid;
      flags_q   <= in_valid ? merged_flags : '0;
      if (in_valid) result <= merged;
    end
  end

  assign flag_invalid = flags_q.invalid;
  assign flag_denorm  = flags_q.denorm;
endmodule

// File: rtl/fpw_checker.sv
module fpw_checker
  import fpw_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int MAX_W = 256,
  localparam int HI_W = VEC_W - DP_W
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [1:0]       mode,
  input logic             mask_en,
  input logic             mask_bit,
  input logic             zero_sel,
  input logic [HI_W-1:0]  upper_src,
  input logic [MAX_W-1:0] dest_old,
  input logic             out_valid,
  input logic [MAX_W-1:0] result,
  input logic             flag_invalid,
  input logic             flag_denorm
);
  p_valid_follow_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_flags_qual_r9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!flag_invalid && !flag_denorm));
  p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  p_legacy_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (mode == 2'd0 || mode == 2'd3)) |=> result[MAX_W-1:DP_W] == $past(dest_old[MAX_W-1:DP_W]));
  p_upper_copy_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (mode == 2'd1 || mode == 2'd2)) |=> result[VEC_W-1:DP_W] == $past(upper_src));
  p_top_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (mode == 2'd1 || mode == 2'd2)) |=> result[MAX_W-1:VEC_W] == '0);
  p_mask_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'd2 && mask_en && !mask_bit && zero_sel) |=> result[DP_W-1:0] == '0);
  p_mask_merge_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'd2 && mask_en && !mask_bit && !zero_sel) |=> result[DP_W-1:0] == $past(dest_old[DP_W-1:0]));
  p_mask_noflag_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'd2 && mask_en && !mask_bit) |=> (!flag_invalid && !flag_denorm));
  p_invalid_nan_r4: assert property (@(posedge clk) disable iff (rst)
    flag_invalid |-> (&result[DP_W-2 -: DP_EXP_W]) && result[DP_FRAC_W-1]);
  p_denorm_normal_r2: assert property (@(posedge clk) disable iff (rst)
    flag_denorm |-> (|result[DP_W-2 -: DP_EXP_W]) && !(&result[DP_W-2 -: DP_EXP_W]));
  p_flags_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(flag_invalid && flag_denorm));
  p_reset_clear_r10: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && result == '0 && !flag_invalid && !flag_denorm));
endmodule

bind fp_widen_unit fpw_checker #(.VEC_W(VEC_W), .MAX_W(MAX_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .mode         (mode),
  .mask_en      (mask_en),
  .mask_bit     (mask_bit),
  .zero_sel     (zero_sel),
  .upper_src    (upper_src),
  .dest_old     (dest_old),
  .out_valid    (out_valid),
  .result       (result),
  .flag_invalid (flag_invalid),
  .flag_denorm  (flag_denorm)
);

// File: tb/fp_widen_unit_test.sv
`timescale 1ns/1ps
module fp_widen_unit_test;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [1:0]   mode;
  logic         mask_en, mask_bit, zero_sel;
  logic [31:0]  conv_src;
  logic [63:0]  upper_src;
  logic [255:0] dest_old;
  logic         out_valid;
  logic [255:0] result;
  logic         flag_invalid, flag_denorm;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  fp_widen_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
    .mask_en(mask_en), .mask_bit(mask_bit), .zero_sel(zero_sel),
    .conv_src(conv_src), .upper_src(upper_src), .dest_old(dest_old),
    .out_valid(out_valid), .result(result),
    .flag_invalid(flag_invalid), .flag_denorm(flag_denorm)
  );

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Arithmetic reference: value = 1.m * 2^ex, rebuilt for binary64.
  function automatic logic [63:0] ref_dp(input logic [31:0] x, output logic inv, output logic den);
    logic       s;
    int         e;
    int         ex;
    logic [23:0] m;
    s = x[31]; e = int'(x[30:23]); inv = 1'b0; den = 1'b0;
    if (e == 255) begin
      if (x[22:0] == 23'd0) return {s, 11'h7ff, 52'd0};
      inv = !x[22];
      return {s, 11'h7ff, x[22:0] | 23'h400000, 29'd0};
    end
    if (e == 0 && x[22:0] == 23'd0) return {s, 63'd0};
    if (e == 0) begin
      den = 1'b1;
      m = {1'b0, x[22:0]};
      ex = -126;
      while (!m[23]) begin
        m = m << 1;
        ex--;
      end
    end else begin
      m = {1'b1, x[22:0]};
      ex = e - 127;
    end
    return {s, 11'(ex + 1023), m[22:0], 29'd0};
  endfunction

  task automatic run_op(input logic [1:0] md, input logic men, input logic mb, input logic zs,
                        input logic [31:0] x, input string lo_tag, input string hi_tag);
    logic [63:0]  dp;
    logic         inv, den;
    logic [255:0] exp_res;
    logic         lane;
    logic [255:0] held;
    @(negedge clk);
    mode = md; mask_en = men; mask_bit = mb; zero_sel = zs; conv_src = x;
    upper_src = {$urandom, $urandom};
    dest_old  = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    in_valid  = 1'b1;
    dp = ref_dp(x, inv, den);
    lane = (md != 2'd2) || !men || mb;
    exp_res = dest_old;
    if (md == 2'd1 || md == 2'd2) begin
      exp_res[255:128] = '0;
      exp_res[127:64]  = upper_src;
    end
    if (lane) exp_res[63:0] = dp;
    else if (zs) exp_res[63:0] = '0;
    if (!lane) begin inv = 1'b0; den = 1'b0; end
    @(negedge clk);
    in_valid = 1'b0;
    check({lo_tag, " low lane+flags"}, {190'd0, result[63:0], flag_invalid, flag_denorm},
          {190'd0, exp_res[63:0], inv, den});
    check({hi_tag, " upper lanes"}, {64'd0, result[255:64]}, {64'd0, exp_res[255:64]});
    check("R9 valid strobe", {255'd0, out_valid}, 256'd1);
    held = result;
    @(negedge clk);
    check("R9 idle hold", {result[253:0], out_valid, flag_invalid | flag_denorm},
          {held[253:0], 2'b00});
  endtask

  function automatic string class_tag(input logic [31:0] x);
    if (x[30:23] == 8'hff) return (x[22:0] == 0) ? "R3" : "R4";
    if (x[30:23] == 8'h00) return (x[22:0] == 0) ? "R3" : "R2";
    return "R1";
  endfunction

  initial begin
    int unsigned cyc = 0;
    while (cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [22:0] fpat [6];
    rst = 1'b1; in_valid = 1'b0; mode = 2'd0; mask_en = 1'b0; mask_bit = 1'b0;
    zero_sel = 1'b0; conv_src = '0; upper_src = '0; dest_old = '1;
    repeat (3) @(negedge clk);
    check("R10 reset state", {result[253:0], out_valid, flag_invalid | flag_denorm}, 256'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R10 after reset", {result[253:0], out_valid, flag_invalid | flag_denorm}, 256'd0);

    // Every exponent code, boundary fraction patterns, both signs, legacy mode.
    fpat[0] = 23'h000000; fpat[1] = 23'h000001; fpat[2] = 23'h400000;
    fpat[3] = 23'h7fffff; fpat[4] = 23'h2aaaaa;
    for (int e = 0; e < 256; e++) begin
      fpat[5] = 23'(e * 32'h9e37 + 3);
      for (int f = 0; f < 6; f++) begin
        for (int s = 0; s < 2; s++) begin
          logic [31:0] x;
          x = {1'(s), 8'(e), fpat[f]};
          run_op(2'd0, 1'b0, 1'b0, 1'b0, x, class_tag(x), "R5");
        end
      end
    end

    // Every policy, mask and zeroing combination.
    for (int md = 0; md < 4; md++) begin
      for (int c = 0; c < 8; c++) begin
        for (int v = 0; v < 4; v++) begin
          logic [31:0] x;
          string lt, ht;
          x = (v == 0) ? 32'h7f800001 : (v == 1) ? 32'h00000003 :
              (v == 2) ? 32'hc0490fdb : 32'hffc12345;
          if (md == 2 && c[2] && !c[1]) lt = "R8";
          else if (md == 2 || md == 1) lt = "R7";
          else lt = class_tag(x);
          ht = (md == 3) ? "R11" : (md == 0) ? "R5" : "R6";
          run_op(2'(md), c[2], c[1], c[0], x, lt, ht);
        end
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule